// File: doc/BRIEF.md
# 16-QAM Symbol Mapper and Slicer

This block holds both baseband ends of a 16-point quadrature amplitude link. The transmit half takes a serial bit stream, one bit per handshake. It gathers the bits into groups of four and turns each group into a pair of signed amplitudes: one for the in-phase (I) axis and one for the quadrature (Q) axis. Each amplitude takes one of four evenly spaced odd values. Carrier mixing, pulse shaping and anything else in the analog chain sit outside the block.

The receive half takes one pair of signed soft values per handshake. Each axis is compared with three fixed decision levels. That comparison yields two bits per axis, so four bits per symbol, and the block sends them back out serially. Every edge of the block is a valid/ready stream. Both halves share one clock and one synchronous active-high reset, and otherwise work independently of each other.

Top module: `qam16_mapper_slicer`

## Requirements
- R1: A transmit symbol is produced only after four bits have been accepted. The first bit accepted becomes bit 3 (the MSB) of the 4-bit group. The symbol becomes valid on the clock edge that follows acceptance of the fourth bit.
- R2: Bits 3:2 of the group select the I amplitude and bits 1:0 select the Q amplitude. The two axes are mapped independently.
- R3: Each 2-bit pair is mapped with a Gray code to a signed 3-bit two's-complement level: 00 gives -3 (101), 01 gives -1 (111), 11 gives +1 (001) and 10 gives +3 (011).
- R4: While a symbol is held with tx_sym_ready low, tx_sym_valid, tx_sym_i and tx_sym_q stay unchanged. tx_bit_ready goes low only when three bits are already gathered and a symbol is still pending.
- R5: Each soft value is sliced against thresholds -2, 0 and +2. A value v at or above 2 gives 10, 0 to 1 gives 11, -2 to -1 gives 01, and below -2 gives 00. A value that lies exactly on a threshold resolves to the higher level.
- R6: The four recovered bits leave serially in the order I bit 1, I bit 0, Q bit 1, Q bit 0. One bit is sent per rx_bit handshake.
- R7: While rx_bit_ready is low, rx_bit_valid and rx_bit stay unchanged. rx_soft_ready is low while more than the final bit of the current symbol is still pending.
- R8: Synchronous reset clears both valid outputs and discards any partly gathered transmit bits, so the next four bits accepted form a fresh group.
- R9: The most negative and the most positive soft values slice to 00 and 10 respectively, with no wraparound.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tx_bit_valid | input | 1 | Serial transmit bit is valid |
| tx_bit | input | 1 | Serial transmit bit |
| tx_bit_ready | output | 1 | Block accepts a transmit bit |
| tx_sym_valid | output | 1 | Mapped symbol is valid |
| tx_sym_i | output | 3 | I amplitude, signed |
| tx_sym_q | output | 3 | Q amplitude, signed |
| tx_sym_ready | input | 1 | Downstream takes the symbol |
| rx_soft_valid | input | 1 | Soft pair is valid |
| rx_soft_i | input | SOFT_W | I soft value, signed |
| rx_soft_q | input | SOFT_W | Q soft value, signed |
| rx_soft_ready | output | 1 | Block accepts a soft pair |
| rx_bit_valid | output | 1 | Recovered bit is valid |
| rx_bit | output | 1 | Recovered serial bit |
| rx_bit_ready | input | 1 | Downstream takes the bit |

## Verification
The bench drives soft values that sit exactly on -2, 0 and +2, and also the two extremes of the soft range. A slicer with a strict comparison would resolve a tie one level low, and a slicer that compares without sign would turn the negative extreme into a positive decision.

All sixteen groups are sent and checked against the Gray table. A design that swapped the I and Q pairs, or that used plain binary level order, would show a wrong amplitude on the first mismatched group.

Stalls are applied on both output streams. A reset is placed between the second and third bit of a group. A design that overwrote a pending symbol, or that kept stale bits through reset, would emit an extra symbol or a misaligned one.

// File: rtl/qam16_mapper_slicer.sv
module qam16_mapper_slicer #(
  parameter int SOFT_W = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     tx_bit_valid,
  input  logic                     tx_bit,
  output logic                     tx_bit_ready,
  output logic                     tx_sym_valid,
  output logic signed [2:0]        tx_sym_i,
  output logic signed [2:0]        tx_sym_q,
  input  logic                     tx_sym_ready,
  input  logic                     rx_soft_valid,
  input  logic signed [SOFT_W-1:0] rx_soft_i,
  input  logic signed [SOFT_W-1:0] rx_soft_q,
  output logic                     rx_soft_ready,
  output logic                     rx_bit_valid,
  output logic                     rx_bit,
  input  logic                     rx_bit_ready
);
  localparam logic signed [SOFT_W-1:0] TH_HI = SOFT_W'(2);
  localparam logic signed [SOFT_W-1:0] TH_LO = -SOFT_W'(2);

  function automatic logic signed [2:0] to_level(input logic [1:0] p);
    case (p)
      2'b00:   to_level = 3'sb101;
      2'b01:   to_level = 3'sb111;
      2'b11:   to_level = 3'sb001;
      default: to_level = 3'sb011;
    endcase
  endfunction

  function automatic logic [1:0] slice(input logic signed [SOFT_W-1:0] v);
    if (v >= TH_HI)        slice = 2'b10;
    else if (!v[SOFT_W-1]) slice = 2'b11;
    else if (v >= TH_LO)   slice = 2'b01;
    else                   slice = 2'b00;
  endfunction

  // transmit side
  logic [2:0] gather;
  logic [1:0] gcnt;
  logic       tx_take, last_bit;
  logic [3:0] quad;

  assign last_bit     = gcnt == 2'd3;
  assign tx_bit_ready = ~(last_bit & tx_sym_valid & ~tx_sym_ready);
  assign tx_take      = tx_bit_valid & tx_bit_ready;
  assign quad         = {gather, tx_bit};

  always_ff @(posedge clk) begin
    if (rst) begin
      gcnt         <= 2'd0;
      tx_sym_valid <= 1'b0;
    end else begin
      if (tx_take) begin
        gather <= {gather[1:0], tx_bit};
        gcnt   <= gcnt + 2'd1;
      end
      if (tx_take && last_bit) begin
        tx_sym_valid <= 1'b1;
        tx_sym_i     <= to_level(quad[3:2]);
        tx_sym_q     <= to_level(quad[1:0]);
      end else if (tx_sym_ready) begin
        tx_sym_valid <= 1'b0;
      end
    end
  end

  a_r1_no_early_symbol: assert property (@(posedge clk) disable iff (rst)
    (!tx_sym_valid && !(tx_take && last_bit)) |=> !tx_sym_valid);
  a_r3_odd_level: assert property (@(posedge clk) disable iff (rst)
    tx_sym_valid |-> (tx_sym_i[0] && tx_sym_q[0]));
  a_r4_tx_hold: assert property (@(posedge clk) disable iff (rst)
    (tx_sym_valid && !tx_sym_ready) |=>
      (tx_sym_valid && $stable(tx_sym_i) && $stable(tx_sym_q)));

  // receive side
  logic [3:0] rq;
  logic [2:0] left;
  logic       rx_take;

  assign rx_bit_valid  = left != 3'd0;
  assign rx_bit        = rq[3];
  assign rx_soft_ready = (left == 3'd0) | ((left == 3'd1) & rx_bit_ready);
  assign rx_take       = rx_soft_valid & rx_soft_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      left <= 3'd0;
    end else if (rx_take) begin
      rq   <= {slice(rx_soft_i), slice(rx_soft_q)};
      left <= 3'd4;
    end else if (rx_bit_valid && rx_bit_ready) begin
      rq   <= {rq[2:0], 1'b0};
      left <= left - 3'd1;
    end
  end

  a_r5_high_tie: assert property (@(posedge clk) disable iff (rst)
    (rx_take && rx_soft_i >= TH_HI) |=> (rx_bit_valid && rx_bit));
  a_r9_neg_extreme: assert property (@(posedge clk) disable iff (rst)
    (rx_take && rx_soft_i < TH_LO) |=> (rx_bit_valid && !rx_bit));
  a_r7_rx_hold: assert property (@(posedge clk) disable iff (rst)
    (rx_bit_valid && !rx_bit_ready) |=> (rx_bit_valid && $stable(rx_bit)));
  a_r8_reset_clears: assert property (@(posedge clk)
    rst |=> (!tx_sym_valid && !rx_bit_valid));
endmodule

// File: tb/qam16_mapper_slicer_bench.sv
module qam16_mapper_slicer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int SW = 8;

  logic clk = 1'b0, rst = 1'b1;
  logic tx_bit_valid = 1'b0, tx_bit = 1'b0, tx_bit_ready;
  logic tx_sym_valid, tx_sym_ready = 1'b1;
  logic signed [2:0] tx_sym_i, tx_sym_q;
  logic rx_soft_valid = 1'b0, rx_soft_ready;
  logic signed [SW-1:0] rx_soft_i = '0, rx_soft_q = '0;
  logic rx_bit_valid, rx_bit, rx_bit_ready = 1'b1;

  int checks = 0, errors = 0, tx_mode = 0, rx_mode = 0, pat = 0;
  bit done = 1'b0;
  logic [5:0] tx_q[$];
  logic       rx_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  qam16_mapper_slicer #(.SOFT_W(SW)) u_qam16_mapper_slicer (
    .clk(clk), .rst(rst),
    .tx_bit_valid(tx_bit_valid), .tx_bit(tx_bit), .tx_bit_ready(tx_bit_ready),
    .tx_sym_valid(tx_sym_valid), .tx_sym_i(tx_sym_i), .tx_sym_q(tx_sym_q),
    .tx_sym_ready(tx_sym_ready),
    .rx_soft_valid(rx_soft_valid), .rx_soft_i(rx_soft_i), .rx_soft_q(rx_soft_q),
    .rx_soft_ready(rx_soft_ready),
    .rx_bit_valid(rx_bit_valid), .rx_bit(rx_bit), .rx_bit_ready(rx_bit_ready));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [2:0] exp_level(input logic [1:0] p);
    case (p)
      2'b00: return 3'b101;
      2'b01: return 3'b111;
      2'b11: return 3'b001;
      default: return 3'b011;
    endcase
  endfunction

  function automatic logic [1:0] exp_bits(input int v);
    if (v >= 2) return 2'b10;
    if (v >= 0) return 2'b11;
    if (v >= -2) return 2'b01;
    return 2'b00;
  endfunction

  always @(posedge clk) begin
    #1;
    pat++;
    tx_sym_ready = (tx_mode == 0) || (tx_mode == 1 && (pat % 3) != 0);
    rx_bit_ready = (rx_mode == 0) || (rx_mode == 1 && (pat % 5) != 1);
  end

  always @(negedge clk) if (!rst && tx_sym_valid && tx_sym_ready) begin
    if (tx_q.size() == 0) check(1'b0, "R1/R8 unexpected symbol", 1, 0);
    else begin
      logic [5:0] e;
      e = tx_q.pop_front();
      check({tx_sym_i, tx_sym_q} == e, "R1/R2/R3 symbol", {tx_sym_i, tx_sym_q}, e);
    end
  end

  always @(negedge clk) if (!rst && rx_bit_valid && rx_bit_ready) begin
    if (rx_q.size() == 0) check(1'b0, "R6 unexpected bit", 1, 0);
    else begin
      logic e;
      e = rx_q.pop_front();
      check(rx_bit == e, "R5/R6/R9 bit", rx_bit, e);
    end
  end

  task automatic put_bit(input logic b);
    @(negedge clk);
    tx_bit_valid = 1'b1; tx_bit = b;
    while (!tx_bit_ready) @(negedge clk);
    @(posedge clk); #1;
    tx_bit_valid = 1'b0;
  endtask

  task automatic put_nib(input logic [3:0] n);
    tx_q.push_back({exp_level(n[3:2]), exp_level(n[1:0])});
    for (int k = 3; k >= 0; k--) put_bit(n[k]);
  endtask

  task automatic put_soft(input int vi, input int vq);
    logic [1:0] bi, bq;
    bi = exp_bits(vi); bq = exp_bits(vq);
    rx_q.push_back(bi[1]); rx_q.push_back(bi[0]);
    rx_q.push_back(bq[1]); rx_q.push_back(bq[0]);
    @(negedge clk);
    rx_soft_valid = 1'b1; rx_soft_i = SW'(vi); rx_soft_q = SW'(vq);
    while (!rx_soft_ready) @(negedge clk);
    @(posedge clk); #1;
    rx_soft_valid = 1'b0;
  endtask

  task automatic drain();
    while (tx_q.size() != 0 || rx_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    check(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    int vals[9] = '{-128, -3, -2, -1, 0, 1, 2, 3, 127};
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!tx_sym_valid, "R8 reset tx_sym_valid", tx_sym_valid, 0);
    check(!rx_bit_valid, "R8 reset rx_bit_valid", rx_bit_valid, 0);
    check(tx_bit_ready && rx_soft_ready, "R8 reset readies", tx_bit_ready, 1);

    for (int n = 0; n < 16; n++) put_nib(4'(n));
    drain();

    // R1: three bits do not make a symbol
    tx_q.push_back({exp_level(2'b10), exp_level(2'b11)});
    put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
    repeat (4) @(negedge clk);
    check(!tx_sym_valid, "R1 partial group", tx_sym_valid, 0);
    put_bit(1'b1);
    drain();

    // R4: pending symbol blocks the fourth bit
    tx_mode = 2;
    put_nib(4'b0110);
    put_bit(1'b1); put_bit(1'b1); put_bit(1'b0);
    repeat (4) @(negedge clk);
    check(!tx_bit_ready, "R4 tx_bit_ready under stall", tx_bit_ready, 0);
    check(tx_sym_valid && tx_sym_i == 3'sb111 && tx_sym_q == 3'sb011,
          "R4 held symbol", {tx_sym_i, tx_sym_q}, 6'b111011);
    tx_q.push_back({exp_level(2'b11), exp_level(2'b01)});
    tx_mode = 0;
    put_bit(1'b1);
    drain();

    tx_mode = 1;
    for (int n = 0; n < 24; n++) put_nib(4'((n * 7 + 3) % 16));
    drain();
    tx_mode = 0;

    // R8: reset in the middle of a group
    put_bit(1'b1); put_bit(1'b1);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    check(!tx_sym_valid, "R8 after mid-group reset", tx_sym_valid, 0);
    put_nib(4'b0001);
    drain();

    foreach (vals[a]) foreach (vals[b]) put_soft(vals[a], vals[b]);
    drain();

    // R7: output stall holds bit and blocks the next soft pair
    rx_mode = 2;
    put_soft(2, -3);
    repeat (4) @(negedge clk);
    check(!rx_soft_ready, "R7 rx_soft_ready under stall", rx_soft_ready, 0);
    check(rx_bit_valid && rx_bit == 1'b1, "R7 held first bit", rx_bit, 1);
    rx_mode = 0;
    drain();

    rx_mode = 1;
    for (int n = 0; n < 30; n++) put_soft((n * 5) % 11 - 5, (n * 3) % 9 - 4);
    drain();
    rx_mode = 0;

    finish_run();
  end
endmodule